// File: doc/BRIEF.md
# Lane-Partitioned Integer Add/Subtract Unit

This block adds or subtracts two wide operands lane by lane. The operand width is a parameter with a default of 128 bits. A lane-size select splits each operand into 8-, 16-, 32- or 64-bit lanes. Every lane computes its own result. No carry or borrow passes from one lane into its neighbour. An arithmetic-mode select picks one of three arithmetics: plain wraparound, signed saturation or unsigned saturation. Saturation is offered only for 8-bit and 16-bit lanes.

The unit sits in the integer vector execution path of a processor-style datapath. The surrounding pipeline supplies already-decoded operands and selects, and the unit returns one result vector. A request that the unit cannot serve raises an illegal-operation output and forces the result to zero. Two requests fall in this class: saturation with 32- or 64-bit lanes, and the reserved mode code.

A parameter chooses between a registered output and a purely combinational one. The registered variant is the default.

Top module: `lane_addsub_unit`

## Requirements
- R1: `lane_sel` sets the lane width. Code 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 gives 32-bit lanes and 3 gives 64-bit lanes. Lane k occupies bits [k*W +: W], where W is the lane width.
- R2: With `mode_sel` = 0 (wraparound) and `sub_en` = 0, each lane holds (a + b) mod 2^W. This holds for every lane width.
- R3: With `mode_sel` = 1 (signed saturation) and 8- or 16-bit lanes, each lane holds the exact signed sum or difference. A result above the lane maximum is clamped to 0x7F or 0x7FFF. A result below the lane minimum is clamped to 0x80 or 0x8000.
- R4: With `mode_sel` = 2 (unsigned saturation) and 8- or 16-bit lanes, an add that overflows gives all ones. A subtract that goes below zero gives zero. Any other result is exact.
- R5: `sub_en` = 1 selects subtraction in every mode. Each lane then computes the first operand minus the second.
- R6: Two requests are illegal: `mode_sel` = 3, and `mode_sel` of 1 or 2 with `lane_sel` of 2 or 3. For an illegal request `illegal_op` is 1 and `result` is all zeros. For every other request `illegal_op` is 0.
- R7: With REGISTERED = 1, `result` and `illegal_op` reflect the inputs present at a rising clock edge and change only at that edge. While `rst_n` is low, both outputs are 0.
- R8: A carry or borrow out of the top bit of a lane never changes any bit of the next lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | DATA_W | First operand (minuend when subtracting) |
| op_b | input | DATA_W | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| lane_sel | input | 2 | Lane width code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| mode_sel | input | 2 | 0 = wraparound, 1 = signed saturation, 2 = unsigned saturation, 3 = reserved |
| result | output | DATA_W | Lane-wise result |
| illegal_op | output | 1 | High for an unsupported mode and lane-width pair |

## Verification
Byte lanes are swept exhaustively. Every lane receives the same first operand, while the sixteen lanes carry sixteen different second operands, so all 65,536 byte pairs are tried in each mode and direction. This sweep separates the exact, clamped-high and clamped-low paths in both signed and unsigned arithmetic.

Word lanes are driven with a grid of values at the signed and unsigned edges (0x7FFF, 0x8000, 0xFFFF, 0x0000 and their neighbours). This grid exposes any clamp that uses the byte-level sign or carry instead of the word-level one.

Random vectors cover every combination of lane width and mode, including the reserved and illegal ones. They check that each lane width partitions the carry chain at the right place. A directed all-ones plus one case shows that the carry stays in its own lane, and a check made before and after a clock edge confirms the output register timing.

// File: rtl/lane_addsub_pkg.sv
package lane_addsub_pkg;

   typedef enum logic [1:0] {
      LS_B8  = 2'd0,
      LS_B16 = 2'd1,
      LS_B32 = 2'd2,
      LS_B64 = 2'd3
   } lane_size_e;

   typedef enum logic [1:0] {
      AM_WRAP = 2'd0,
      AM_SSAT = 2'd1,
      AM_USAT = 2'd2,
      AM_RSVD = 2'd3
   } arith_mode_e;

   // decoded operation controls shared by the datapath stages
   typedef struct packed {
      logic invert;    // subtract: invert second operand, inject carry 1
      logic sat_s;     // signed clamp active
      logic sat_u;     // unsigned clamp active
      logic wide16;    // saturation lanes are 16 bits wide
      logic illegal;   // unsupported request
   } op_ctl_t;

   localparam int BYTE_W      = 8;
   localparam int MAX_LANE_B  = 8;   // widest lane in bytes
   localparam int SAT_VARIANT = 2;   // 8-bit and 16-bit saturation lanes

endpackage

// File: rtl/lane_op_decode.sv
module lane_op_decode
   import lane_addsub_pkg::*;
#(
   parameter int NBYTES = 16
)(
   input  logic              sub_en,
   input  lane_size_e        lane_sel,
   input  arith_mode_e       mode_sel,
   output op_ctl_t           ctl,
   output logic [NBYTES-1:0] lane_start
);

   logic       want_sat;
   logic       wide_lane;
   logic [3:0] span_m1;

   always_comb begin
      want_sat    = (mode_sel == AM_SSAT) || (mode_sel == AM_USAT);
      wide_lane   = (lane_sel == LS_B32) || (lane_sel == LS_B64);
      ctl.illegal = (mode_sel == AM_RSVD) || (want_sat && wide_lane);
      ctl.invert  = sub_en;
      ctl.sat_s   = (mode_sel == AM_SSAT) && !ctl.illegal;
      ctl.sat_u   = (mode_sel == AM_USAT) && !ctl.illegal;
      ctl.wide16  = (lane_sel == LS_B16);
      span_m1     = (4'd1 << lane_sel) - 4'd1;
   end

   // a byte starts a lane when its index within the widest lane is a
   // multiple of the selected lane size in bytes
   for (genvar i = 0; i < NBYTES; i++) begin : g_start
      localparam logic [3:0] IDX = 4'(i % MAX_LANE_B);
      assign lane_start[i] = ((IDX & span_m1) == 4'd0);
   end

endmodule

// File: rtl/lane_seg_adder.sv
module lane_seg_adder
   import lane_addsub_pkg::*;
#(
   parameter int NBYTES = 16,
   localparam int DW    = NBYTES * BYTE_W
)(
   input  logic [DW-1:0]     a,
   input  logic [DW-1:0]     b,
   input  logic              invert,
   input  logic [NBYTES-1:0] lane_start,
   output logic [DW-1:0]     sum,
   output logic [NBYTES-1:0] carry
);

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic       cin;
      logic [7:0] b_eff;

      if (i == 0) begin : g_first
         assign cin = invert;
      end else begin : g_chain
         // the carry chain is cut at every lane start
         assign cin = lane_start[i] ? invert : carry[i-1];
      end

      assign b_eff = b[i*BYTE_W +: BYTE_W] ^ {BYTE_W{invert}};
      assign {carry[i], sum[i*BYTE_W +: BYTE_W]} =
         {1'b0, a[i*BYTE_W +: BYTE_W]} + {1'b0, b_eff} + 9'(cin);
   end

endmodule

// File: rtl/lane_sat_fixup.sv
module lane_sat_fixup
   import lane_addsub_pkg::*;
#(
   parameter int NBYTES = 16,
   localparam int DW    = NBYTES * BYTE_W
)(
   input  logic [DW-1:0]     a,
   input  logic [DW-1:0]     b,
   input  logic [DW-1:0]     sum,
   input  logic [NBYTES-1:0] carry,
   input  op_ctl_t           ctl,
   output logic [DW-1:0]     res
);

   // one variant per saturating lane width: 1 byte and 2 bytes
   for (genvar g = 0; g < SAT_VARIANT; g++) begin : g_sat
      localparam int LB = 1 << g;
      localparam int LW = LB * BYTE_W;
      localparam int NL = NBYTES / LB;

      logic [DW-1:0] sres;

      for (genvar k = 0; k < NL; k++) begin : g_lane
         localparam int LO   = k * LW;
         localparam int HI   = LO + LW - 1;
         localparam int TOPB = (k + 1) * LB - 1;

         logic          a_s, b_s, r_s;
         logic          s_ovf, u_ovf;
         logic [LW-1:0] s_lim, u_lim, lres;

         always_comb begin
            a_s   = a[HI];
            b_s   = b[HI] ^ ctl.invert;
            r_s   = sum[HI];
            s_ovf = (a_s == b_s) && (r_s != a_s);
            s_lim = a_s ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
            // add: carry out means overflow; subtract: no carry means borrow
            u_ovf = carry[TOPB] ^ ctl.invert;
            u_lim = ctl.invert ? {LW{1'b0}} : {LW{1'b1}};
            if (ctl.sat_s && s_ovf)
               lres = s_lim;
            else if (ctl.sat_u && u_ovf)
               lres = u_lim;
            else
               lres = sum[HI:LO];
         end

         assign sres[HI:LO] = lres;
      end
   end

   always_comb begin
      if (ctl.illegal)
         res = '0;
      else if (ctl.wide16)
         res = g_sat[1].sres;
      else
         res = g_sat[0].sres;
   end

endmodule

// File: rtl/lane_addsub_unit.sv
module lane_addsub_unit
   import lane_addsub_pkg::*;
#(
   parameter int DATA_W     = 128,
   parameter bit REGISTERED = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              sub_en,
   input  logic [1:0]        lane_sel,
   input  logic [1:0]        mode_sel,
   output logic [DATA_W-1:0] result,
   output logic              illegal_op
);

   localparam int NBYTES = DATA_W / BYTE_W;

   if ((DATA_W % (MAX_LANE_B * BYTE_W)) != 0 || DATA_W < MAX_LANE_B * BYTE_W)
   begin : g_bad_width
      initial $error("lane_addsub_unit: DATA_W must be a positive multiple of 64");
   end

   op_ctl_t           ctl;
   logic [NBYTES-1:0] lane_start;
   logic [DATA_W-1:0] sum_raw;
   logic [NBYTES-1:0] carry;
   logic [DATA_W-1:0] res_c;

   lane_op_decode #(.NBYTES(NBYTES)) u_dec (
      .sub_en     (sub_en),
      .lane_sel   (lane_size_e'(lane_sel)),
      .mode_sel   (arith_mode_e'(mode_sel)),
      .ctl        (ctl),
      .lane_start (lane_start)
   );

   lane_seg_adder #(.NBYTES(NBYTES)) u_add (
      .a          (op_a),
      .b          (op_b),
      .invert     (ctl.invert),
      .lane_start (lane_start),
      .sum        (sum_raw),
      .carry      (carry)
   );

   lane_sat_fixup #(.NBYTES(NBYTES)) u_fix (
      .a     (op_a),
      .b     (op_b),
      .sum   (sum_raw),
      .carry (carry),
      .ctl   (ctl),
      .res   (res_c)
   );

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result     <= '0;
            illegal_op <= 1'b0;
         end else begin
            result     <= res_c;
            illegal_op <= ctl.illegal;
         end
      end

      // R6: a flagged request leaves an all-zero result at the output
      p_illegal_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
         illegal_op |-> (result == '0));
   end else begin : g_comb
      assign result     = res_c;
      assign illegal_op = ctl.illegal;
   end

   // R6: the clamp stage honours the decoder's illegal flag
   p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.illegal |-> (res_c == '0));

   // R2: wraparound with a zero second operand returns the first operand
   p_wrap_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'd0 && op_b == '0) |-> (res_c == op_a));

   for (genvar i = 0; i < NBYTES; i++) begin : g_chk
      // R4: unsigned saturating byte add never drops below the first operand
      p_usat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_sel == 2'd2 && lane_sel == 2'd0 && !sub_en)
         |-> (res_c[i*8 +: 8] >= op_a[i*8 +: 8]));

      // R4: unsigned saturating byte subtract never exceeds the first operand
      p_usat_ceil_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_sel == 2'd2 && lane_sel == 2'd0 && sub_en)
         |-> (res_c[i*8 +: 8] <= op_a[i*8 +: 8]));

      // R3: two non-negative bytes never give a negative signed saturated sum
      p_ssat_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_sel == 2'd1 && lane_sel == 2'd0 && !sub_en
          && !op_a[i*8+7] && !op_b[i*8+7])
         |-> !res_c[i*8+7]);

      // R8: a zero byte lane in wraparound add is untouched by its neighbour
      p_lane_isolation_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_sel == 2'd0 && lane_sel == 2'd0 && !sub_en
          && op_b[i*8 +: 8] == 8'd0)
         |-> (res_c[i*8 +: 8] == op_a[i*8 +: 8]));
   end

endmodule

// File: tb/lane_addsub_unit_test.sv
`timescale 1ns/1ps
module lane_addsub_unit_test;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [127:0] op_a, op_b;
   logic         sub_en;
   logic [1:0]   lane_sel, mode_sel;
   logic [127:0] result;
   logic         illegal_op;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   lane_addsub_unit uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_a       (op_a),
      .op_b       (op_b),
      .sub_en     (sub_en),
      .lane_sel   (lane_sel),
      .mode_sel   (mode_sel),
      .result     (result),
      .illegal_op (illegal_op)
   );

   // expected value from the requirements: {illegal, result}
   function automatic logic [128:0] model(input logic [127:0] a, input logic [127:0] b,
                                          input logic s, input logic [1:0] ls,
                                          input logic [1:0] md);
      logic [127:0] res = '0;
      int           w   = 8 << ls;
      int           n   = 128 / w;
      logic [63:0]  mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      if (md == 2'd3 || (md != 2'd0 && ls >= 2'd2))
         return {1'b1, 128'd0};
      for (int k = 0; k < n; k++) begin
         logic [63:0] la = 64'(a >> (k * w)) & mask;
         logic [63:0] lb = 64'(b >> (k * w)) & mask;
         logic [63:0] r;
         if (md == 2'd0) begin
            r = s ? (la - lb) : (la + lb);
         end else if (md == 2'd1) begin
            longint half = longint'(1) << (w - 1);
            longint sa = longint'(la);
            longint sb = longint'(lb);
            longint t;
            if (sa >= half) sa = sa - 2 * half;
            if (sb >= half) sb = sb - 2 * half;
            t = s ? (sa - sb) : (sa + sb);
            if (t > half - 1) t = half - 1;
            if (t < -half) t = -half;
            r = 64'(t);
         end else begin
            longint t = s ? (longint'(la) - longint'(lb)) : (longint'(la) + longint'(lb));
            if (t < 0) t = 0;
            if (t > longint'(mask)) t = longint'(mask);
            r = 64'(t);
         end
         res = res | (128'(r & mask) << (k * w));
      end
      return {1'b0, res};
   endfunction

   function automatic string tag_of(input logic s, input logic [1:0] ls, input logic [1:0] md);
      if (md == 2'd3 || (md != 2'd0 && ls >= 2'd2)) return "R6";
      if (md == 2'd1) return "R3";
      if (md == 2'd2) return "R4";
      if (s)          return "R5";
      return "R2";
   endfunction

   task automatic check(input logic [128:0] e, input string tag);
      checks++;
      if (result !== e[127:0] || illegal_op !== e[128]) begin
         errors++;
         $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                  tag, result, illegal_op, e[127:0], e[128]);
      end
   endtask

   // drive at a falling edge, check at the next falling edge
   task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic s,
                        input logic [1:0] ls, input logic [1:0] md, input string tag);
      op_a = a; op_b = b; sub_en = s; lane_sel = ls; mode_sel = md;
      @(negedge clk);
      check(model(a, b, s, ls, md), tag);
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   initial begin
      logic [15:0] cv [10] = '{16'h0000, 16'h0001, 16'h7FFE, 16'h7FFF, 16'h8000,
                               16'h8001, 16'hFFFE, 16'hFFFF, 16'h00FF, 16'h0100};
      rst_n = 1'b0; op_a = '0; op_b = '0; sub_en = 1'b0; lane_sel = '0; mode_sel = '0;
      repeat (3) @(negedge clk);
      // R7: reset state
      check({1'b0, 128'd0}, "R7 reset");
      rst_n = 1'b1;
      @(negedge clk);

      // exhaustive byte pairs: all lanes share a, each lane gets its own b
      for (int md = 0; md < 3; md++)
         for (int s = 0; s < 2; s++)
            for (int i = 0; i < 256; i++)
               for (int j = 0; j < 16; j++) begin
                  logic [127:0] a = {16{8'(i)}};
                  logic [127:0] b;
                  for (int k = 0; k < 16; k++) b[k*8 +: 8] = 8'(j * 16 + k);
                  apply(a, b, 1'(s), 2'd0, 2'(md), tag_of(1'(s), 2'd0, 2'(md)));
               end

      // word lanes on the signed and unsigned edges
      for (int md = 0; md < 3; md++)
         for (int s = 0; s < 2; s++)
            for (int i = 0; i < 10; i++)
               for (int j = 0; j < 10; j++) begin
                  logic [127:0] a, b;
                  for (int k = 0; k < 8; k++) begin
                     a[k*16 +: 16] = cv[(i + k) % 10];
                     b[k*16 +: 16] = cv[(j + 2 * k) % 10];
                  end
                  apply(a, b, 1'(s), 2'd1, 2'(md), tag_of(1'(s), 2'd1, 2'(md)));
               end

      // random vectors over every lane size and mode
      for (int n = 0; n < 2000; n++) begin
         logic [1:0] ls = 2'($urandom_range(0, 3));
         logic [1:0] md = 2'($urandom_range(0, 3));
         logic       s  = 1'($urandom_range(0, 1));
         apply(rnd128(), rnd128(), s, ls, md, {"R1/", tag_of(s, ls, md)});
      end

      // R8: a carry out of each lane top must not reach the next lane
      for (int ls = 0; ls < 4; ls++) begin
         apply({128{1'b1}}, 128'd1, 1'b0, 2'(ls), 2'd0, "R8 carry");
         apply(128'd0, 128'd1, 1'b1, 2'(ls), 2'd0, "R8 borrow");
      end

      // R6: explicit illegal combinations
      apply(rnd128(), rnd128(), 1'b0, 2'd2, 2'd1, "R6 ssat32");
      apply(rnd128(), rnd128(), 1'b1, 2'd3, 2'd2, "R6 usat64");
      apply(rnd128(), rnd128(), 1'b0, 2'd0, 2'd3, "R6 reserved");

      // R7: output holds until the next rising edge
      begin
         logic [128:0] prev = model(128'd5, 128'd3, 1'b0, 2'd0, 2'd0);
         apply(128'd5, 128'd3, 1'b0, 2'd0, 2'd0, "R7 setup");
         op_a = 128'd9; op_b = 128'd2; sub_en = 1'b1;
         #2;
         check(prev, "R7 hold before edge");
         @(negedge clk);
         check(model(128'd9, 128'd2, 1'b1, 2'd0, 2'd0), "R7 update after edge");
      end

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule